// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a small 8-bit processor core. It collects a parameterised set of interrupt sources and decides when the core must branch to a service routine. Each source owns three bits: a sticky event flag, an enable and a priority select. The controller combines these bits with two global control bits and a mode bit, and picks the vector address to branch to. At an instruction boundary reported by the core it emits a one-cycle take strobe.

There are two modes. In compatibility mode (mode bit 0), control bit 7 is the master enable and control bit 6 gates the sources marked as peripherals. Every interrupt then goes to 0x000008. In priority mode (mode bit 1), bit 7 enables the high-priority sources, which go to 0x000008, and bit 6 enables the low-priority sources, which go to 0x000018. A high-priority request may preempt a low-priority routine. A two-entry in-service record makes sure each return strobe re-arms the enable of the level it closes.

Software reaches the state through one write port. The return-from-interrupt strobe comes from the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source's flag goes to 1 on the cycle after its event input is high, whatever its enable and the global bits hold. A flag falls only when the flag register is written (wr_sel 0, bit i of wr_data is source i).
- R2: After reset, all flags, enables, priority bits, both control bits, the mode bit and both in-service bits are 0, and irq_take is 0.
- R3: With the mode bit at 0 (written with wr_sel 4, data bit 7), a source requests when its flag and enable are set and control bit 7 is set. A source marked in PERIPH_MASK also needs control bit 6. Control bits are written with wr_sel 3, data bits 7 and 6. The vector is 0x000008, and priority bits (wr_sel 2) have no effect. Enables use wr_sel 1.
- R4: With the mode bit at 1, a flagged and enabled source with priority bit 1 requests when control bit 7 is set and vectors to 0x000008. One with priority bit 0 requests when control bit 6 is set and vectors to 0x000018.
- R5: irq_take rises only for one cycle, in the cycle after a clock edge at which insn_bnd was high and a request was eligible. irq_vec holds the chosen address while irq_take is high. No take happens while insn_bnd stays low.
- R6: Accepting an interrupt clears the governing control bit and sets the matching in-service bit. The governing bit is bit 7 for compatibility or high priority, and bit 6 for low priority. A return strobe closes the high level if it is in service, and otherwise the low level. It clears that in-service bit and sets that level's control bit again.
- R7: In priority mode a high request is accepted while low service is active. A low request is not accepted while high service is active.
- R8: When high and low requests are eligible at the same boundary, the high vector is taken and the low flag stays set. The low request is then taken once it is eligible again.
- R9: A return strobe with no level in service changes neither control bit.
- R10: An event sampled at edge E with insn_bnd held high produces irq_take after edge E+1, not after edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | NSRC | Per-source event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 flag, 1 enable, 2 priority, 3 control, 4 mode |
| wr_data | input | DATA_W | Write data |
| insn_bnd | input | 1 | Core is at an instruction boundary |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_take | output | 1 | One-cycle take strobe |
| irq_vec | output | 24 | Vector address |
| src_flag | output | NSRC | Current flag bits |
| glb_en_hi | output | 1 | Control bit 7 |
| glb_en_lo | output | 1 | Control bit 6 |
| prio_mode | output | 1 | Mode bit |
| svc_high | output | 1 | High (or compatibility) level in service |
| svc_low | output | 1 | Low level in service |

## Verification
A register write or an event pulse becomes visible on the outputs right after the edge that samples it. An eligible request at a boundary edge raises irq_take and updates irq_vec after that same edge. The control bit clears and the in-service bit sets at that same edge. An event therefore reaches irq_take two edges after it is sampled. The bench drives every input 1 ns after a rising edge and checks each result 1 ns after the edge that produces it, one edge per stimulus step.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    typedef enum logic [2:0] {
        SEL_FLAG = 3'd0,
        SEL_EN   = 3'd1,
        SEL_PRI  = 3'd2,
        SEL_CTL  = 3'd3,
        SEL_MODE = 3'd4
    } reg_sel_e;

    localparam int VEC_W = 24;
    localparam logic [VEC_W-1:0] VEC_HIGH = 24'h000008;
    localparam logic [VEC_W-1:0] VEC_LOW  = 24'h000018;

    typedef struct packed {
        logic             mode;
        logic             ctl_hi;
        logic             ctl_lo;
        logic             svc_hi;
        logic             svc_lo;
        logic             take;
        logic [VEC_W-1:0] vec;
    } seq_st_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_prio_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NSRC-1:0]   flag_o,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   pri_o
);
    typedef struct packed {
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pri;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_FLAG: bank_d.flag = wr_data[NSRC-1:0];
                SEL_EN:   bank_d.en   = wr_data[NSRC-1:0];
                SEL_PRI:  bank_d.pri  = wr_data[NSRC-1:0];
                default:  ;
            endcase
        end
        bank_d.flag = bank_d.flag | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign flag_o = bank_q.flag;
    assign en_o   = bank_q.en;
    assign pri_o  = bank_q.pri;
endmodule

// File: rtl/irq_req_eval.sv
module irq_req_eval #(
    parameter int              NSRC        = 8,
    parameter logic [NSRC-1:0] PERIPH_MASK = '0
) (
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] pri,
    input  logic            mode,
    input  logic            ctl_hi,
    input  logic            ctl_lo,
    input  logic            svc_hi,
    output logic            hi_req,
    output logic            lo_req
);
    logic [NSRC-1:0] act_hi, act_lo, act_core, act_per;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic live;
        assign live        = flag[i] & en[i];
        assign act_hi[i]   = live & pri[i];
        assign act_lo[i]   = live & ~pri[i];
        assign act_per[i]  = live & PERIPH_MASK[i];
        assign act_core[i] = live & ~PERIPH_MASK[i];
    end

    always_comb begin
        if (mode) begin
            hi_req = ctl_hi & (|act_hi);
            lo_req = ctl_lo & (|act_lo) & ~svc_hi;
        end else begin
            hi_req = ctl_hi & ((|act_core) | (ctl_lo & (|act_per)));
            lo_req = 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int              NSRC        = 8,
    parameter int              DATA_W      = (NSRC > 8) ? NSRC : 8,
    parameter logic [NSRC-1:0] PERIPH_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              insn_bnd,
    input  logic              irq_ret,
    output logic              irq_take,
    output logic [23:0]       irq_vec,
    output logic [NSRC-1:0]   src_flag,
    output logic              glb_en_hi,
    output logic              glb_en_lo,
    output logic              prio_mode,
    output logic              svc_high,
    output logic              svc_low
);
    logic [NSRC-1:0] en_w, pri_w;
    logic            hi_req, lo_req;
    seq_st_t         st_d, st_q;

    irq_src_bank #(.NSRC(NSRC), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_o(src_flag), .en_o(en_w), .pri_o(pri_w)
    );

    irq_req_eval #(.NSRC(NSRC), .PERIPH_MASK(PERIPH_MASK)) u_eval (
        .flag(src_flag), .en(en_w), .pri(pri_w), .mode(st_q.mode),
        .ctl_hi(st_q.ctl_hi), .ctl_lo(st_q.ctl_lo), .svc_hi(st_q.svc_hi),
        .hi_req(hi_req), .lo_req(lo_req)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        if (wr_en && reg_sel_e'(wr_sel) == SEL_CTL) begin
            st_d.ctl_hi = wr_data[7];
            st_d.ctl_lo = wr_data[6];
        end
        if (wr_en && reg_sel_e'(wr_sel) == SEL_MODE)
            st_d.mode = wr_data[7];
        if (irq_ret) begin
            if (st_q.svc_hi) begin
                st_d.svc_hi = 1'b0;
                st_d.ctl_hi = 1'b1;
            end else if (st_q.svc_lo) begin
                st_d.svc_lo = 1'b0;
                st_d.ctl_lo = 1'b1;
            end
        end
        if (insn_bnd) begin
            if (hi_req) begin
                st_d.take   = 1'b1;
                st_d.vec    = VEC_HIGH;
                st_d.ctl_hi = 1'b0;
                st_d.svc_hi = 1'b1;
            end else if (lo_req) begin
                st_d.take   = 1'b1;
                st_d.vec    = VEC_LOW;
                st_d.ctl_lo = 1'b0;
                st_d.svc_lo = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_take  = st_q.take;
    assign irq_vec   = st_q.vec;
    assign glb_en_hi = st_q.ctl_hi;
    assign glb_en_lo = st_q.ctl_lo;
    assign prio_mode = st_q.mode;
    assign svc_high  = st_q.svc_hi;
    assign svc_low   = st_q.svc_lo;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
    parameter int NSRC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] evt,
    input logic            wr_en,
    input logic [2:0]      wr_sel,
    input logic            insn_bnd,
    input logic            irq_take,
    input logic [23:0]     irq_vec,
    input logic [NSRC-1:0] src_flag,
    input logic            glb_en_hi,
    input logic            glb_en_lo,
    input logic            prio_mode,
    input logic            svc_high,
    input logic            svc_low
);
    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt) & ~src_flag) == '0)); // R1
    AST_FLAG_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(src_flag) & ~src_flag)) |-> $past(wr_en && wr_sel == 3'd0)); // R1
    AST_COMPAT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(prio_mode) || irq_vec == 24'h000008)); // R3
    AST_LEGAL_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_vec == 24'h000008 || irq_vec == 24'h000018)); // R4
    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_take) |-> $past(insn_bnd)); // R5
    AST_HIGH_ACCEPT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vec == 24'h000008) |-> (!glb_en_hi && svc_high)); // R6
    AST_LOW_ACCEPT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vec == 24'h000018) |-> (!glb_en_lo && svc_low)); // R6
    AST_LOW_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_vec == 24'h000018) |-> !$past(svc_high)); // R7
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .wr_sel(wr_sel),
    .insn_bnd(insn_bnd), .irq_take(irq_take), .irq_vec(irq_vec),
    .src_flag(src_flag), .glb_en_hi(glb_en_hi), .glb_en_lo(glb_en_lo),
    .prio_mode(prio_mode), .svc_high(svc_high), .svc_low(svc_low)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam logic [NS-1:0] PMASK = 4'b1100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic insn_bnd = 1'b0, irq_ret = 1'b0;
    logic irq_take;
    logic [23:0] irq_vec;
    logic [NS-1:0] src_flag;
    logic glb_en_hi, glb_en_lo, prio_mode, svc_high, svc_low;
    int checks = 0, errors = 0, cycles = 0;

    irq_prio_ctrl #(.NSRC(NS), .DATA_W(8), .PERIPH_MASK(PMASK)) u0 (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .insn_bnd(insn_bnd), .irq_ret(irq_ret),
        .irq_take(irq_take), .irq_vec(irq_vec), .src_flag(src_flag),
        .glb_en_hi(glb_en_hi), .glb_en_lo(glb_en_lo), .prio_mode(prio_mode),
        .svc_high(svc_high), .svc_low(svc_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_evt(input logic [NS-1:0] m);
        evt = m;
        tick();
        evt = '0;
    endtask

    task automatic boundary();
        insn_bnd = 1'b1;
        tick();
        insn_bnd = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
    endtask

    initial begin
        #1;
        do_reset();
        // R2 reset state
        chk("R2", {src_flag, glb_en_hi, glb_en_lo, prio_mode, svc_high, svc_low, irq_take}, 0);

        // Sweep: mode x control bits x source x enable x priority (R1 R3 R4 R5 R6)
        for (int m = 0; m < 2; m++)
        for (int c = 0; c < 4; c++)
        for (int s = 0; s < NS; s++)
        for (int e = 0; e < 2; e++)
        for (int p = 0; p < 2; p++) begin
            logic c7, c6, exp_take, use_lo;
            logic [23:0] exp_vec;
            c7 = c[1]; c6 = c[0];
            do_reset();
            wr(3'd4, 8'(m << 7));
            wr(3'd3, 8'(c << 6));
            wr(3'd1, 8'(e << s));
            wr(3'd2, 8'(p << s));
            pulse_evt(NS'(1 << s));
            chk("R1", 32'(src_flag), 32'(1 << s));
            use_lo = (m == 1) && (p == 0);
            if (m == 1) exp_take = (e == 1) && (p == 1 ? c7 : c6);
            else        exp_take = (e == 1) && c7 && (PMASK[s] ? c6 : 1'b1);
            exp_vec = use_lo ? 24'h000018 : 24'h000008;
            boundary();
            chk(m == 1 ? "R4" : "R3", 32'(irq_take), 32'(exp_take));
            if (exp_take) begin
                chk(m == 1 ? "R4" : "R3", 32'(irq_vec), 32'(exp_vec));
                chk("R6", {30'd0, glb_en_hi, glb_en_lo},
                    use_lo ? {30'd0, c7, 1'b0} : {30'd0, 1'b0, c6});
                chk("R6", {30'd0, svc_high, svc_low}, use_lo ? 32'd1 : 32'd2);
                tick();
                chk("R5", 32'(irq_take), 0);
                wr(3'd0, 8'h00);
                ret();
                chk("R6", {28'd0, glb_en_hi, glb_en_lo, svc_high, svc_low},
                    {28'd0, c7, c6, 2'b00});
            end
        end

        // R5 / R10: no take without boundary, then latency of two edges
        do_reset();
        wr(3'd3, 8'hC0);
        wr(3'd1, 8'h01);
        pulse_evt(4'b0001);
        for (int k = 0; k < 4; k++) begin
            chk("R5", 32'(irq_take), 0);
            tick();
        end
        wr(3'd0, 8'h00);
        chk("R1", 32'(src_flag), 0);
        insn_bnd = 1'b1;
        evt = 4'b0001;
        tick();
        evt = '0;
        chk("R10", 32'(irq_take), 0);
        tick();
        insn_bnd = 1'b0;
        chk("R10", 32'(irq_take), 1);

        // R7: preemption and hold-off, R6 nested return, R9 empty return
        do_reset();
        wr(3'd4, 8'h80);
        wr(3'd3, 8'hC0);
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h01);
        pulse_evt(4'b0010);
        boundary();
        chk("R7", 32'(irq_vec), 32'h18);
        wr(3'd0, 8'h00);
        pulse_evt(4'b0001);
        boundary();
        chk("R7", {8'd0, irq_take, irq_vec}, {8'd0, 1'b1, 24'h000008});
        chk("R7", {30'd0, svc_high, svc_low}, 3);
        wr(3'd0, 8'h00);
        pulse_evt(4'b0010);
        boundary();
        chk("R7", 32'(irq_take), 0);
        wr(3'd0, 8'h00);
        ret();
        chk("R6", {28'd0, glb_en_hi, glb_en_lo, svc_high, svc_low}, 32'b1001);
        ret();
        chk("R6", {28'd0, glb_en_hi, glb_en_lo, svc_high, svc_low}, 32'b1100);
        wr(3'd3, 8'h00);
        ret();
        chk("R9", {30'd0, glb_en_hi, glb_en_lo}, 0);

        // R8: simultaneous high and low
        do_reset();
        wr(3'd4, 8'h80);
        wr(3'd3, 8'hC0);
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h01);
        pulse_evt(4'b0011);
        boundary();
        chk("R8", {8'd0, irq_take, irq_vec}, {8'd0, 1'b1, 24'h000008});
        chk("R8", 32'(src_flag), 32'b0011);
        wr(3'd0, 8'h02);
        ret();
        boundary();
        chk("R8", {8'd0, irq_take, irq_vec}, {8'd0, 1'b1, 24'h000018});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule